// File: doc/BRIEF.md
# PLL Operating Mode and Holdover Controller

This block supervises a digital PLL and moves it between three operating modes without software help. The modes are free-running, locked to the reference, and digital holdover. It watches a reference-valid flag and the loop's lock indicator. From these it selects the frequency word that steers the oscillator. In free-run that word is a fixed centre value. In locked mode it is the loop's own control word. In holdover it is a stored last-good value.

The last-good value is recorded only when lock has been stable for a programmable number of consecutive update ticks. Each sample is committed one qualifying tick after it is taken. As a result, the samples taken just before a reference failure never reach the history.

The block also chooses the loop bandwidth. Acquisition bandwidth is used outside locked mode. An override forces locked bandwidth at all times. When the reference returns during holdover, the controller re-locks in one of two ways. In revertive operation it re-locks on its own. In non-revertive operation it waits for an explicit accept strobe.

Top module: `pll_mode_ctrl`

## Requirements
- R1: On reset the mode output is free-run. Mode encoding: free-run = 0, locked = 1, holdover = 2. After reset the oscillator word equals the NOMINAL_FREQ parameter and the history holds nothing.
- R2: Free-run moves to locked at a clock edge where `ref_ok` and `loop_locked` are both high. With either one low, the mode stays free-run.
- R3: In locked mode, a clock edge that sees `ref_ok` low moves the mode to holdover on that same edge.
- R4: `osc_freq` follows `loop_freq` in locked mode and equals NOMINAL_FREQ in free-run. In holdover it is the stored history word and stays constant.
- R5: The controller counts a run of qualifying ticks. A qualifying tick is an edge with `tick` high while the mode is locked and `ref_ok` and `loop_locked` are both high. From the QUAL_TICKS-th tick of a run onward, each qualifying tick takes a candidate sample of `loop_freq`. A candidate is committed to history only at the next qualifying tick. Any clock edge without qualification ends the run and discards the candidate. The history does not change on edges where `tick` is low.
- R6: Holdover entered before any sample has been committed drives NOMINAL_FREQ.
- R7: With `revert_en` high, holdover returns to locked at the first edge where `ref_ok` is high.
- R8: With `revert_en` low, holdover returns to locked only at an edge where `ref_ok` and `accept_stb` are both high. Otherwise it stays in holdover.
- R9: `use_lock_bw` is high in locked mode, or whenever `force_lock_bw` is high. Otherwise it is low.
- R10: `bw_code` is `bw_lock_sel` when `use_lock_bw` is high and `bw_acq_sel` otherwise. The codes are 0 = 18 Hz, 1 = 35 Hz and 2 = 70 Hz. The reserved code 3 comes out as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_ok | input | 1 | Reference currently qualified as valid |
| loop_locked | input | 1 | Loop reports phase/frequency lock |
| tick | input | 1 | Loop update strobe, one cycle per control-word update |
| loop_freq | input | FREQ_W | Frequency-control word produced by the loop filter |
| revert_en | input | 1 | 1 = revertive, 0 = non-revertive re-lock |
| accept_stb | input | 1 | Permits re-lock from holdover in non-revertive operation |
| force_lock_bw | input | 1 | Use locked bandwidth regardless of mode |
| bw_lock_sel | input | 2 | Locked bandwidth setting |
| bw_acq_sel | input | 2 | Acquisition bandwidth setting |
| mode | output | 2 | Current operating mode |
| use_lock_bw | output | 1 | 1 = locked bandwidth selected |
| bw_code | output | 2 | Bandwidth setting handed to the loop |
| osc_freq | output | FREQ_W | Frequency word driving the oscillator |

## Verification
Several corner cases target the history logic.

- **Failure right after a candidate sample.** The reference fails one tick after the first candidate is taken. A design that commits samples at once would replay that last pre-failure word instead of the nominal value.
- **Broken lock run.** Lock drops for one cycle in the middle of a run. A counter that is not cleared would qualify too early and store a word from the unstable period.
- **Non-revertive re-lock.** The reference returns without an accept strobe, and an accept strobe arrives while the reference is still bad. A controller that ignored either condition would leave holdover too early.
- **Bandwidth selection.** The bench uses the reserved code and the force override while in free-run. This exposes a wrong-bandwidth select or a reserved code passed through unchanged.

// File: rtl/pllmode_pkg.sv
package pllmode_pkg;

    typedef enum logic [1:0] {
        MODE_FREE   = 2'd0,
        MODE_LOCKED = 2'd1,
        MODE_HOLD   = 2'd2
    } pll_mode_e;

    typedef enum logic [1:0] {
        BW_18HZ = 2'd0,
        BW_35HZ = 2'd1,
        BW_70HZ = 2'd2,
        BW_RSVD = 2'd3
    } bw_sel_e;

    typedef struct packed {
        logic ref_ok;
        logic loop_locked;
    } loop_status_t;

    typedef struct packed {
        logic    use_lock;
        bw_sel_e code;
    } bw_out_t;

    function automatic bw_sel_e bw_sanitize(input logic [1:0] raw);
        bw_sel_e res;
        if (raw == 2'd3) res = BW_18HZ;
        else             res = bw_sel_e'(raw);
        return res;
    endfunction

endpackage

// File: rtl/pllmode_fsm.sv
module pllmode_fsm
    import pllmode_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  loop_status_t status,
    input  logic         revert_en,
    input  logic         accept_stb,
    output pll_mode_e    mode
);

    pll_mode_e mode_nx;

    always_comb begin
        mode_nx = mode;
        unique case (mode)
            MODE_FREE: begin
                if (status.ref_ok && status.loop_locked) mode_nx = MODE_LOCKED;
            end
            MODE_LOCKED: begin
                if (!status.ref_ok) mode_nx = MODE_HOLD;
            end
            MODE_HOLD: begin
                if (status.ref_ok && (revert_en || accept_stb)) mode_nx = MODE_LOCKED;
            end
            default: mode_nx = MODE_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) mode <= MODE_FREE;
        else     mode <= mode_nx;
    end

    AST_FAIL_TO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_LOCKED && !status.ref_ok) |=> (mode == MODE_HOLD)); // R3

    AST_FREE_NEVER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FREE) |=> (mode != MODE_HOLD)); // R2

    AST_NONREV_WAITS: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_HOLD && !revert_en && !accept_stb) |=> (mode == MODE_HOLD)); // R8

    AST_REVERT_RELOCK: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_HOLD && revert_en && status.ref_ok) |=> (mode == MODE_LOCKED)); // R7

endmodule

// File: rtl/pllmode_history.sv
module pllmode_history #(
    parameter int FREQ_W     = 32,
    parameter int QUAL_TICKS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              qual,
    input  logic              tick,
    input  logic [FREQ_W-1:0] loop_freq,
    output logic [FREQ_W-1:0] hist_word,
    output logic              hist_valid
);

    localparam int                CNT_W  = $clog2(QUAL_TICKS + 1);
    localparam logic [CNT_W-1:0]  QUAL_C = CNT_W'(QUAL_TICKS);

    logic [CNT_W-1:0]  run_cnt;
    logic [CNT_W:0]    run_now;
    logic [FREQ_W-1:0] cand_word;
    logic              cand_valid;

    assign run_now = {1'b0, run_cnt} + (CNT_W+1)'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt    <= '0;
            cand_word  <= '0;
            cand_valid <= 1'b0;
            hist_word  <= '0;
            hist_valid <= 1'b0;
        end else if (!qual) begin
            run_cnt    <= '0;
            cand_valid <= 1'b0;
        end else if (tick) begin
            if (run_cnt < QUAL_C) run_cnt <= run_cnt + CNT_W'(1);
            if (run_now >= {1'b0, QUAL_C}) begin
                cand_word  <= loop_freq;
                cand_valid <= 1'b1;
                if (cand_valid) begin
                    hist_word  <= cand_word;
                    hist_valid <= 1'b1;
                end
            end
        end
    end

    AST_HIST_QUIET_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(hist_word)); // R5

    AST_HIST_QUIET_UNQUAL: assert property (@(posedge clk) disable iff (rst)
        !qual |=> $stable(hist_word)); // R5

    AST_HIST_STICKY: assert property (@(posedge clk) disable iff (rst)
        hist_valid |=> hist_valid); // R5

endmodule

// File: rtl/pllmode_bw.sv
module pllmode_bw
    import pllmode_pkg::*;
(
    input  pll_mode_e  mode,
    input  logic       force_lock,
    input  logic [1:0] lock_sel,
    input  logic [1:0] acq_sel,
    output bw_out_t    bw
);

    always_comb begin
        bw.use_lock = force_lock || (mode == MODE_LOCKED);
        bw.code     = bw.use_lock ? bw_sanitize(lock_sel) : bw_sanitize(acq_sel);
    end

    always_comb begin
        AST_BW_NO_RSVD: assert (bw.code != BW_RSVD); // R10
    end

endmodule

// File: rtl/pll_mode_ctrl.sv
module pll_mode_ctrl
    import pllmode_pkg::*;
#(
    parameter int                FREQ_W       = 32,
    parameter int                QUAL_TICKS   = 4,
    parameter logic [FREQ_W-1:0] NOMINAL_FREQ = {1'b1, {(FREQ_W-1){1'b0}}}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_ok,
    input  logic              loop_locked,
    input  logic              tick,
    input  logic [FREQ_W-1:0] loop_freq,
    input  logic              revert_en,
    input  logic              accept_stb,
    input  logic              force_lock_bw,
    input  logic [1:0]        bw_lock_sel,
    input  logic [1:0]        bw_acq_sel,
    output logic [1:0]        mode,
    output logic              use_lock_bw,
    output logic [1:0]        bw_code,
    output logic [FREQ_W-1:0] osc_freq
);

    loop_status_t      status;
    pll_mode_e         cur_mode;
    logic              qual;
    logic [FREQ_W-1:0] hist_word;
    logic              hist_valid;
    bw_out_t           bw;

    assign status = '{ref_ok: ref_ok, loop_locked: loop_locked};
    assign qual   = (cur_mode == MODE_LOCKED) && ref_ok && loop_locked;

    pllmode_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .status     (status),
        .revert_en  (revert_en),
        .accept_stb (accept_stb),
        .mode       (cur_mode)
    );

    pllmode_history #(
        .FREQ_W     (FREQ_W),
        .QUAL_TICKS (QUAL_TICKS)
    ) u_hist (
        .clk        (clk),
        .rst        (rst),
        .qual       (qual),
        .tick       (tick),
        .loop_freq  (loop_freq),
        .hist_word  (hist_word),
        .hist_valid (hist_valid)
    );

    pllmode_bw u_bw (
        .mode       (cur_mode),
        .force_lock (force_lock_bw),
        .lock_sel   (bw_lock_sel),
        .acq_sel    (bw_acq_sel),
        .bw         (bw)
    );

    always_comb begin
        unique case (cur_mode)
            MODE_LOCKED: osc_freq = loop_freq;
            MODE_HOLD:   osc_freq = hist_valid ? hist_word : NOMINAL_FREQ;
            default:     osc_freq = NOMINAL_FREQ;
        endcase
    end

    assign mode        = cur_mode;
    assign use_lock_bw = bw.use_lock;
    assign bw_code     = bw.code;

    AST_HOLD_WORD_STEADY: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == MODE_HOLD && $past(cur_mode) == MODE_HOLD) |-> $stable(osc_freq)); // R4

    AST_LOCKED_USES_LOCK_BW: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == MODE_LOCKED) |-> use_lock_bw); // R9

    AST_HOLD_EMPTY_NOMINAL: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == MODE_HOLD && !hist_valid) |-> (osc_freq == NOMINAL_FREQ)); // R6

endmodule

// File: tb/pll_mode_ctrl_test.sv
`timescale 1ns/1ps
module pll_mode_ctrl_test;

    localparam int          FW  = 32;
    localparam logic [31:0] NOM = 32'h8000_0000;
    localparam logic [1:0]  MF = 2'd0, ML = 2'd1, MH = 2'd2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_ok = 0, loop_locked = 0, tick = 0;
    logic [31:0] loop_freq = '0;
    logic        revert_en = 1, accept_stb = 0, force_lock_bw = 0;
    logic [1:0]  bw_lock_sel = 2'd2, bw_acq_sel = 2'd1;
    logic [1:0]  mode;
    logic        use_lock_bw;
    logic [1:0]  bw_code;
    logic [31:0] osc_freq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pll_mode_ctrl #(.FREQ_W(FW), .QUAL_TICKS(4), .NOMINAL_FREQ(NOM)) uut (
        .clk(clk), .rst(rst), .ref_ok(ref_ok), .loop_locked(loop_locked),
        .tick(tick), .loop_freq(loop_freq), .revert_en(revert_en),
        .accept_stb(accept_stb), .force_lock_bw(force_lock_bw),
        .bw_lock_sel(bw_lock_sel), .bw_acq_sel(bw_acq_sel), .mode(mode),
        .use_lock_bw(use_lock_bw), .bw_code(bw_code), .osc_freq(osc_freq)
    );

    typedef struct packed {
        logic        r;
        logic        l;
        logic        t;
        logic [31:0] f;
        logic [1:0]  st;
        logic [31:0] osc;
        logic [1:0]  bw;
    } vec_t;

    // revertive, no force, lock code 2, acquisition code 1; QUAL_TICKS = 4
    localparam vec_t TBL [14] = '{
        '{1'b0, 1'b0, 1'b0, 32'hA1, MF, NOM,   2'd1},
        '{1'b1, 1'b0, 1'b1, 32'hA2, MF, NOM,   2'd1},
        '{1'b1, 1'b1, 1'b1, 32'h11, ML, 32'h11, 2'd2},
        '{1'b1, 1'b1, 1'b1, 32'h12, ML, 32'h12, 2'd2},
        '{1'b1, 1'b1, 1'b1, 32'h13, ML, 32'h13, 2'd2},
        '{1'b1, 1'b1, 1'b0, 32'h14, ML, 32'h14, 2'd2},
        '{1'b1, 1'b1, 1'b1, 32'h15, ML, 32'h15, 2'd2},
        '{1'b1, 1'b1, 1'b1, 32'h16, ML, 32'h16, 2'd2},
        '{1'b1, 1'b1, 1'b1, 32'h17, ML, 32'h17, 2'd2},
        '{1'b1, 1'b1, 1'b1, 32'h18, ML, 32'h18, 2'd2},
        '{1'b0, 1'b1, 1'b1, 32'h19, MH, 32'h17, 2'd1},
        '{1'b0, 1'b0, 1'b1, 32'h99, MH, 32'h17, 2'd1},
        '{1'b1, 1'b0, 1'b0, 32'h20, ML, 32'h20, 2'd2},
        '{1'b0, 1'b0, 1'b0, 32'h21, MH, 32'h17, 2'd1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic l, input logic t,
                        input logic a, input logic [31:0] f);
        @(negedge clk);
        ref_ok = r; loop_locked = l; tick = t; accept_stb = a; loop_freq = f;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; ref_ok = 0; loop_locked = 0; tick = 0; accept_stb = 0;
        @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        chk("R1 mode after reset", 32'(mode), 32'(MF));
        chk("R1 osc after reset", osc_freq, NOM);
        chk("R9 acq bw after reset", 32'(use_lock_bw), 0);

        // table walk: R2 R3 R4 R5 R7 R9 R10
        for (int i = 0; i < 14; i++) begin
            step(TBL[i].r, TBL[i].l, TBL[i].t, 1'b0, TBL[i].f);
            chk($sformatf("R2_R3_R7 mode step %0d", i), 32'(mode), 32'(TBL[i].st));
            chk($sformatf("R4_R5 osc step %0d", i), osc_freq, TBL[i].osc);
            chk($sformatf("R9_R10 bw step %0d", i), 32'(bw_code), 32'(TBL[i].bw));
        end

        // R2: lock without reference keeps free-run
        do_reset();
        step(1'b0, 1'b1, 1'b1, 1'b0, 32'h5);
        chk("R2 no ref stays free", 32'(mode), 32'(MF));

        // R6 / R5: failure one tick after the first candidate gives nominal
        do_reset();
        step(1, 1, 0, 0, 32'h30);
        for (int k = 1; k <= 4; k++) step(1, 1, 1, 0, 32'h30 + 32'(k));
        step(0, 1, 0, 0, 32'h3F);
        chk("R3 hold after fail", 32'(mode), 32'(MH));
        chk("R6 uncommitted candidate not replayed", osc_freq, NOM);

        // R5: broken run restarts the count
        do_reset();
        step(1, 1, 0, 0, 32'h40);
        for (int k = 1; k <= 3; k++) step(1, 1, 1, 0, 32'h40 + 32'(k));
        step(1, 0, 0, 0, 32'h44);
        chk("R5 locked mode kept during lock dip", 32'(mode), 32'(ML));
        for (int k = 1; k <= 3; k++) step(1, 1, 1, 0, 32'h50 + 32'(k));
        step(0, 0, 0, 0, 32'h5F);
        chk("R5 interrupted run stores nothing", osc_freq, NOM);

        // R8 non-revertive
        do_reset();
        revert_en = 0;
        step(1, 1, 0, 0, 32'h60);
        for (int k = 1; k <= 5; k++) step(1, 1, 1, 0, 32'h60 + 32'(k));
        step(0, 0, 0, 0, 32'h6F);
        chk("R4 hold replays committed word", osc_freq, 32'h64);
        for (int k = 0; k < 3; k++) step(1, 1, 0, 0, 32'h70);
        chk("R8 no accept stays hold", 32'(mode), 32'(MH));
        chk("R4 hold word unchanged", osc_freq, 32'h64);
        step(0, 0, 0, 1, 32'h71);
        chk("R8 accept without ref stays hold", 32'(mode), 32'(MH));
        step(1, 1, 0, 1, 32'h72);
        chk("R8 accept with ref relocks", 32'(mode), 32'(ML));
        chk("R4 locked follows loop", osc_freq, 32'h72);
        revert_en = 1;

        // R9 / R10 bandwidth selection in free-run
        do_reset();
        force_lock_bw = 1; bw_lock_sel = 2'd2; bw_acq_sel = 2'd1;
        #1;
        chk("R9 force selects lock bw", 32'(use_lock_bw), 1);
        chk("R10 forced code", 32'(bw_code), 2);
        bw_lock_sel = 2'd3;
        #1;
        chk("R10 reserved lock code", 32'(bw_code), 0);
        force_lock_bw = 0; bw_acq_sel = 2'd3;
        #1;
        chk("R10 reserved acq code", 32'(bw_code), 0);
        bw_acq_sel = 2'd2;
        #1;
        chk("R10 acq code 70Hz", 32'(bw_code), 2);
        chk("R9 free-run acq bw", 32'(use_lock_bw), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule